// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog peripheral on a simple APB-style register port with a 32-bit data path. Software programs a start value and sets the enable bit. A down-counter then runs toward zero, one step for every clock in which the external count-enable input is high and the pause input is low. If software does not restart the counter in time, the counter reaches zero and the next step is a timeout. The timeout either starts a system reset pulse at once, or raises an interrupt first and starts the reset pulse only on the following timeout.

The counter is restarted only by writing one key value to the restart register. Once the enable bit is set, software cannot clear it. The reset pulse has a programmable width. When the pulse ends, the block returns to its power-on state, because the reset it has just issued applies to the block as well. A test bit makes the live counter value readable.

Register map (byte offsets): CTRL 0x00, LOAD 0x04, COUNT 0x08 (read only), RESTART 0x0C (write only), STATUS 0x10 (read only), IRQCLR 0x14 (read to clear). Registers that do not exist at an address read as 0.

Top module: `escalating_watchdog`

## Requirements
- R1: After `rst_n` is released, CTRL, LOAD, COUNT and STATUS read 0, and `irq_o` and `sys_rst_o` are low.
- R2: A write takes effect on the clock edge where `psel`, `penable` and `pwrite` are all high. Writing CTRL with bit 0 set while the block is disabled loads the counter from LOAD. A step at a count of zero is a timeout. With steps on every clock, the first timeout therefore comes LOAD+1 edges after the enabling write.
- R3: When CTRL bit 1 (mode) is 0, a timeout raises `sys_rst_o` on that edge and does not raise `irq_o`.
- R4: When the mode bit is 1, the first timeout sets `irq_o` (STATUS bit 0) without a reset. The counter reloads from LOAD, and the next timeout raises `sys_rst_o`.
- R5: In mode 1, the second timeout raises `sys_rst_o` even if the interrupt was cleared between the two timeouts.
- R6: The counter steps only on clocks where `count_en_i` is high. With `count_en_i` high on every other clock, the timeout comes after 2*(LOAD+1) clocks.
- R7: While `pause_i` is high, the counter holds its value and no timeout occurs. Counting resumes from the held value when `pause_i` falls.
- R8: Writing exactly 0x76 to RESTART while enabled reloads the counter from LOAD and clears both the interrupt and the first-stage flag, so the next timeout in mode 1 is again an interrupt. Any other value written to RESTART has no effect.
- R9: After the enable bit (CTRL bit 0) is set, writing CTRL with bit 0 clear leaves it set, and the counter keeps running. Only a reset clears it.
- R10: `sys_rst_o` stays high for exactly 2^(W+1) clocks, where W is CTRL bits 6:4. When the pulse ends, every register returns to its value after `rst_n`.
- R11: When CTRL bit 2 (test) is 1, COUNT reads the live counter value. When the test bit is 0, COUNT reads 0.
- R12: A read of IRQCLR returns 0 and clears `irq_o`. It does not reload the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| count_en_i | input | 1 | Gates each counter step |
| pause_i | input | 1 | Holds the counter and blocks timeouts |
| irq_o | output | 1 | First-stage timeout interrupt |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The timeout path is driven in four ways:
- count enable held high, which sets the base period of LOAD+1;
- count enable toggling every other clock, which doubles the period and so separates gating from a free-running count;
- pause held high for many times the period, which must block every timeout;
- mode 1 with and without an interrupt clear between the stages, which shows that escalation ignores the clear and that the clear does not reload the counter.

Restart writes with a near-miss key and with the true key are sent while the counter is frozen. This way the COUNT reading shows reload or no reload directly. Pulse widths at the smallest, a middle and the largest code confirm the width decode.

// File: rtl/escalating_watchdog.sv
module escalating_watchdog #(
  parameter int          CNT_W       = 32,
  parameter int          ADDR_W      = 8,
  parameter logic [31:0] RESTART_KEY = 32'h76
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              count_en_i,
  input  logic              pause_i,
  output logic              irq_o,
  output logic              sys_rst_o
);

  localparam int PW_W = 9;
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_LOAD    = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_COUNT   = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_RESTART = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_IRQCLR  = ADDR_W'(8'h14);

  logic             en_q, mode_q, test_q, irq_q, stage_q, rst_active_q;
  logic [2:0]       width_q;
  logic [CNT_W-1:0] load_q, cnt_q;
  logic [PW_W-1:0]  pulse_q;

  logic wr, rd, wr_ctrl, wr_load, restart_hit, clr_hit, en_rise, tick, timeout, escalate;

  assign wr          = psel && penable && pwrite;
  assign rd          = psel && penable && !pwrite;
  assign wr_ctrl     = wr && (paddr == A_CTRL);
  assign wr_load     = wr && (paddr == A_LOAD);
  assign restart_hit = wr && (paddr == A_RESTART) && (pwdata == RESTART_KEY);
  assign clr_hit     = rd && (paddr == A_IRQCLR);
  assign en_rise     = wr_ctrl && pwdata[0] && !en_q;
  assign tick        = en_q && !rst_active_q && count_en_i && !pause_i && !restart_hit;
  assign timeout     = tick && (cnt_q == '0);
  assign escalate    = timeout && (!mode_q || stage_q);

  assign irq_o     = irq_q;
  assign sys_rst_o = rst_active_q;

  always_ff @(posedge clk) begin
    if (!rst_n || (rst_active_q && pulse_q == '0)) begin
      en_q         <= 1'b0;
      mode_q       <= 1'b0;
      test_q       <= 1'b0;
      width_q      <= '0;
      load_q       <= '0;
      cnt_q        <= '0;
      irq_q        <= 1'b0;
      stage_q      <= 1'b0;
      rst_active_q <= 1'b0;
      pulse_q      <= '0;
    end else if (rst_active_q) begin
      pulse_q <= pulse_q - 1'b1;
    end else begin
      if (wr_ctrl) begin
        en_q    <= en_q | pwdata[0];
        mode_q  <= pwdata[1];
        test_q  <= pwdata[2];
        width_q <= pwdata[6:4];
      end
      if (wr_load) load_q <= pwdata[CNT_W-1:0];
      if (clr_hit) irq_q <= 1'b0;
      if (en_rise) begin
        cnt_q <= load_q;
      end else if (restart_hit && en_q) begin
        cnt_q   <= load_q;
        irq_q   <= 1'b0;
        stage_q <= 1'b0;
      end else if (timeout) begin
        cnt_q <= load_q;
        if (escalate) begin
          rst_active_q <= 1'b1;
          pulse_q      <= (PW_W'(2) << width_q) - 1'b1;
        end else begin
          irq_q   <= 1'b1;
          stage_q <= 1'b1;
        end
      end else if (tick) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_comb begin
    case (paddr)
      A_CTRL:   prdata = {25'd0, width_q, 1'b0, test_q, mode_q, en_q};
      A_LOAD:   prdata = 32'(load_q);
      A_COUNT:  prdata = test_q ? 32'(cnt_q) : 32'd0;
      A_STATUS: prdata = {31'd0, irq_q};
      default:  prdata = 32'd0;
    endcase
  end

  // R9
  enable_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !rst_active_q) |=> en_q);

  // R7
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_i && en_q && !rst_active_q && !restart_hit) |=> ($stable(cnt_q) && !sys_rst_o));

  // R6
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en_i && en_q && !rst_active_q && !restart_hit) |=> $stable(cnt_q));

  // R3
  direct_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !mode_q) |=> (sys_rst_o && !$rose(irq_o)));

  // R4
  first_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && mode_q && !stage_q) |=> (irq_o && !sys_rst_o));

  // R8
  restart_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_hit && en_q && !rst_active_q) |=> (cnt_q == $past(load_q) && !irq_o));

  // R12
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !timeout && !rst_active_q) |=> !irq_o);

  // R10
  pulse_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |=> sys_rst_o);

endmodule

// File: tb/sim_escalating_watchdog.sv
module sim_escalating_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        count_en_i = 1'b1, pause_i = 1'b0;
  logic        irq_o, sys_rst_o;

  int nchk = 0, nerr = 0;
  bit done = 0;

  localparam logic [7:0] A_CTRL = 8'h00, A_LOAD = 8'h04, A_COUNT = 8'h08,
                         A_RESTART = 8'h0C, A_STATUS = 8'h10, A_IRQCLR = 8'h14;

  always #4 clk = ~clk;

  escalating_watchdog u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .count_en_i(count_en_i),
    .pause_i(pause_i), .irq_o(irq_o), .sys_rst_o(sys_rst_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic hard_reset();
    @(negedge clk);
    rst_n = 1'b0; psel = 0; penable = 0; count_en_i = 1; pause_i = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic wait_for(input bit use_irq, input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (use_irq ? irq_o : sys_rst_o) begin n = i; break; end
    end
  endtask

  task automatic measure_pulse(output int w);
    w = 0;
    while (sys_rst_o && w < 1000) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    hard_reset();
    apb_rd(A_CTRL, d);   chk("R1 ctrl", d, 0);
    apb_rd(A_LOAD, d);   chk("R1 load", d, 0);
    apb_rd(A_COUNT, d);  chk("R1 count", d, 0);
    apb_rd(A_STATUS, d); chk("R1 status", d, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 rst", sys_rst_o, 0);
  endtask

  task automatic t_mode0();
    logic [31:0] d; int n, w;
    hard_reset();
    apb_wr(A_LOAD, 10);
    apb_wr(A_CTRL, 32'h11);
    wait_for(0, 100, n);
    chk("R2 timeout edge", n, 11);
    chk("R3 no irq", irq_o, 0);
    measure_pulse(w);
    chk("R10 width code1", w, 4);
    apb_rd(A_CTRL, d);
    chk("R10 self clear", d, 0);
  endtask

  task automatic t_mode1();
    int n, w;
    hard_reset();
    apb_wr(A_LOAD, 6);
    apb_wr(A_CTRL, 32'h03);
    wait_for(1, 100, n);
    chk("R4 first stage irq", n, 7);
    chk("R4 no reset first", sys_rst_o, 0);
    wait_for(0, 100, n);
    chk("R4 second stage reset", n, 7);
    measure_pulse(w);
    chk("R10 width code0", w, 2);
  endtask

  task automatic t_mode1_clear();
    logic [31:0] d; int n;
    hard_reset();
    apb_wr(A_LOAD, 30);
    apb_wr(A_CTRL, 32'h03);
    wait_for(1, 100, n);
    chk("R4 irq period", n, 31);
    apb_rd(A_IRQCLR, d);
    chk("R12 clr reads zero", d, 0);
    chk("R12 irq cleared", irq_o, 0);
    wait_for(0, 100, n);
    chk("R5 R12 reset after clear, no reload", n, 29);
  endtask

  task automatic t_pause();
    logic [31:0] d; int n; bit seen;
    hard_reset();
    pause_i = 1;
    apb_wr(A_LOAD, 5);
    apb_wr(A_CTRL, 32'h05);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sys_rst_o || irq_o) seen = 1;
    end
    chk("R7 no timeout paused", seen, 0);
    apb_rd(A_COUNT, d);
    chk("R7 R11 count held", d, 5);
    apb_wr(A_CTRL, 32'h01);
    apb_rd(A_COUNT, d);
    chk("R11 count hidden", d, 0);
    pause_i = 0;
    wait_for(0, 100, n);
    chk("R7 resume", n, 6);
  endtask

  task automatic t_restart();
    logic [31:0] d;
    hard_reset();
    apb_wr(A_LOAD, 9);
    apb_wr(A_CTRL, 32'h05);
    for (int i = 0; i < 4; i++) @(negedge clk);
    pause_i = 1;
    apb_rd(A_COUNT, d);
    chk("R11 live count", d, 5);
    apb_wr(A_RESTART, 32'h75);
    apb_rd(A_COUNT, d);
    chk("R8 wrong key ignored", d, 5);
    apb_wr(A_RESTART, 32'h76);
    apb_rd(A_COUNT, d);
    chk("R8 key reloads", d, 9);
    pause_i = 0;
  endtask

  task automatic t_restart_irq();
    int n;
    hard_reset();
    apb_wr(A_LOAD, 4);
    apb_wr(A_CTRL, 32'h03);
    wait_for(1, 100, n);
    chk("R4 irq", n, 5);
    pause_i = 1;
    apb_wr(A_RESTART, 32'h76);
    chk("R8 restart clears irq", irq_o, 0);
    pause_i = 0;
    wait_for(1, 100, n);
    chk("R8 stage cleared, irq again", n, 5);
    chk("R8 no reset after restart", sys_rst_o, 0);
  endtask

  task automatic t_lock();
    logic [31:0] d; int n;
    hard_reset();
    apb_wr(A_LOAD, 8);
    apb_wr(A_CTRL, 32'h01);
    apb_wr(A_CTRL, 32'h00);
    apb_rd(A_CTRL, d);
    chk("R9 enable locked", d[0], 1);
    wait_for(0, 100, n);
    chk("R9 still counting", n, 5);
  endtask

  task automatic t_count_en();
    logic [31:0] d; int n;
    hard_reset();
    count_en_i = 0;
    apb_wr(A_LOAD, 3);
    apb_wr(A_CTRL, 32'h05);
    for (int i = 0; i < 20; i++) @(negedge clk);
    apb_rd(A_COUNT, d);
    chk("R6 gated hold", d, 3);
    n = -1;
    for (int i = 1; i <= 100; i++) begin
      count_en_i = (i % 2 == 0);
      @(negedge clk);
      if (sys_rst_o) begin n = i; break; end
    end
    chk("R6 half rate", n, 8);
    count_en_i = 1;
  endtask

  task automatic t_width();
    int n, w;
    hard_reset();
    apb_wr(A_CTRL, 32'h71);
    wait_for(0, 10, n);
    chk("R2 zero load", n, 1);
    measure_pulse(w);
    chk("R10 width code7", w, 256);
    hard_reset();
    apb_wr(A_CTRL, 32'h21);
    wait_for(0, 10, n);
    measure_pulse(w);
    chk("R10 width code2", w, 8);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset();
    t_mode0();
    t_mode1();
    t_mode1_clear();
    t_pause();
    t_restart();
    t_restart_irq();
    t_lock();
    t_count_en();
    t_width();
    finish_run();
  end
endmodule